// File: doc/BRIEF.md
# Video Scan Address Reconstructor

When the processor reads an I/O location that no device claims, the data lines keep whatever byte the video generator fetched from display memory in that same cycle. This block works out which display byte that is. It takes a cycle count that restarts at zero with every frame, and the four display mode flags: text, high resolution, second page and the 80-column store mode. From these it produces the main-memory address that the scan is fetching, together with a read request for the system's memory port.

Each line of the scan lasts 65 processor cycles. The count is split into a line number and a tick within the line. The line number gets a fixed start offset and becomes a 9-bit vertical counter. The tick becomes a horizontal counter that stays at zero for two ticks. The two counters are then interleaved into the non-linear display address. A small 4-bit adder with a fixed constant produces the middle address bits. The display mode chooses the page base, and in high-resolution mode the line-within-row bits go into the upper address bits. The request always targets the main memory bank, never the auxiliary one. The address logic is combinational. A parameter picks a registered output stage, which is the default, or a direct pass-through.

Top module: `scan_addr_recon`

## Requirements
- R1: The line number is the cycle count divided by 65 and the tick is the remainder. Count 64 maps to line 0, tick 64; count 65 maps to line 1, tick 0.
- R2: The horizontal counter is the tick minus one, held at zero for tick 0. Ticks 0 and 1 of a line therefore give the same address.
- R3: The vertical counter is the line number plus 250 (hex FA), kept to 9 bits, so it wraps past 511.
- R4: A 4-bit sum is 13 plus horizontal bits [5:3] plus the 4-bit value made of vertical bits [7:6] repeated twice (bits 7:6 at positions 3:2 and again at 1:0). Only the low 4 bits are kept.
- R5: Address bits [9:7] carry vertical bits [5:3], bits [6:3] carry the sum, and bits [2:0] carry horizontal bits [2:0].
- R6: When text mode is on, or high resolution is off, hex 0400 is ORed into the address. If page 2 is on and 80-column store is off, hex 0800 is used instead.
- R7: In high-resolution graphics mode (text off and high resolution on), hex 2000 is ORed in, or hex 4000 under the same page condition as R6. Vertical bits [2:0] go to address bits [12:10].
- R8: With 80-column store on, the page-2 flag has no effect on the address in either mode.
- R9: With the registered output, a probe held high at one rising edge raises the read request for exactly the following cycle. The address for that probe appears in the same cycle. When there is no probe, the request is low and the address holds its last value.
- R10: After reset the read request is low and the address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_cnt_i | input | 15 | Frame-relative processor cycle count |
| mode_text_i | input | 1 | Text display mode flag |
| mode_hires_i | input | 1 | High-resolution graphics flag |
| mode_page2_i | input | 1 | Second display page flag |
| mode_store80_i | input | 1 | 80-column store mode flag |
| probe_i | input | 1 | An unclaimed I/O read is in progress |
| addr_o | output | 16 | Main-memory display address being scanned |
| rd_req_o | output | 1 | Read request for addr_o in the main bank |

## Verification
Two things meet at a line boundary: the division rolls over to the next line, and the horizontal clamp holds zero for two ticks. The bench probes counts 64 and 65 and then 130, 131 and 132. It judges them against addresses it computes from R1 and R2, and checks that the clamp pair is identical while the next tick moves by one. The page choice and the 80-column store override also meet on one probe. There the bench sets page 2 with the store flag both on and off in the text and high-resolution modes, and compares each address with its own model.

// File: rtl/scanaddr_pkg.sv
package scanaddr_pkg;
   localparam int unsigned DEF_CYC_W    = 15;
   localparam int unsigned DEF_LINE_CYC = 65;
   localparam int unsigned DEF_VCNT_W   = 9;
   localparam int unsigned DEF_ADDR_W   = 16;
   localparam int unsigned DEF_VBASE    = 250;
   localparam int unsigned DEF_SUM_K    = 13;

   typedef struct packed {
      logic text;
      logic hires;
      logic page2;
      logic store80;
   } disp_mode_t;
endpackage

// File: rtl/scan_line_split.sv
module scan_line_split #(
   parameter int unsigned CYC_W    = 15,
   parameter int unsigned LINE_CYC = 65,
   localparam int unsigned TICK_W  = $clog2(LINE_CYC),
   localparam int unsigned REM_W   = TICK_W + 1
) (
   input  logic [CYC_W-1:0]  count_i,
   output logic [CYC_W-1:0]  line_o,
   output logic [TICK_W-1:0] tick_o
);
   logic [REM_W-1:0] rem_s [0:CYC_W];
   assign rem_s[0] = '0;

   // restoring long division by the constant line length, one stage per bit
   for (genvar g = 0; g < CYC_W; g++) begin : g_stage
      logic [REM_W-1:0] trial;
      logic             fits;
      assign trial = {rem_s[g][REM_W-2:0], count_i[CYC_W-1-g]};
      assign fits  = (trial >= REM_W'(LINE_CYC));
      assign line_o[CYC_W-1-g] = fits;
      assign rem_s[g+1] = fits ? (trial - REM_W'(LINE_CYC)) : trial;
   end

   assign tick_o = rem_s[CYC_W][TICK_W-1:0];
endmodule

// File: rtl/scan_counter_derive.sv
module scan_counter_derive #(
   parameter int unsigned TICK_W = 7,
   parameter int unsigned VCNT_W = 9,
   parameter int unsigned VBASE  = 250
) (
   input  logic [TICK_W-1:0] tick_i,
   input  logic [VCNT_W-1:0] line_i,
   output logic [TICK_W-1:0] hcnt_o,
   output logic [VCNT_W-1:0] vcnt_o
);
   // horizontal counter sees zero on two consecutive ticks
   always_comb begin
      if (tick_i == '0) hcnt_o = '0;
      else              hcnt_o = tick_i - TICK_W'(1);
   end

   assign vcnt_o = line_i + VCNT_W'(VBASE);
endmodule

// File: rtl/display_addr_map.sv
module display_addr_map
   import scanaddr_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned SUM_K  = 13
) (
   input  logic [5:0]        hcnt_i,
   input  logic [7:0]        vcnt_i,
   input  disp_mode_t        mode_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [3:0] sum4;
   logic [3:0] vrow4;
   logic [9:0] base;
   logic       alt_page;
   logic       gfx_hi;

   assign vrow4    = {vcnt_i[7:6], vcnt_i[7:6]};
   assign sum4     = 4'(SUM_K) + {1'b0, hcnt_i[5:3]} + vrow4;
   assign base     = {vcnt_i[5:3], sum4, hcnt_i[2:0]};
   assign alt_page = mode_i.page2 && !mode_i.store80;
   assign gfx_hi   = !mode_i.text && mode_i.hires;

   always_comb begin
      addr_o = ADDR_W'(base);
      if (gfx_hi) begin
         addr_o[12:10] = vcnt_i[2:0];
         if (alt_page) addr_o[14] = 1'b1;
         else          addr_o[13] = 1'b1;
      end else begin
         if (alt_page) addr_o[11] = 1'b1;
         else          addr_o[10] = 1'b1;
      end
   end
endmodule

// File: rtl/scan_addr_recon.sv
module scan_addr_recon
   import scanaddr_pkg::*;
#(
   parameter int unsigned CYC_W    = DEF_CYC_W,
   parameter int unsigned LINE_CYC = DEF_LINE_CYC,
   parameter int unsigned VCNT_W   = DEF_VCNT_W,
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned VBASE    = DEF_VBASE,
   parameter int unsigned SUM_K    = DEF_SUM_K,
   parameter bit          REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CYC_W-1:0]  cyc_cnt_i,
   input  logic              mode_text_i,
   input  logic              mode_hires_i,
   input  logic              mode_page2_i,
   input  logic              mode_store80_i,
   input  logic              probe_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              rd_req_o
);
   localparam int unsigned TICK_W = $clog2(LINE_CYC);

   // elaboration-time parameter checks
   if (LINE_CYC < 2)       begin : g_bad_line  $error("LINE_CYC must be at least 2"); end
   if (TICK_W < 6)         begin : g_bad_tick  $error("line length too short for hcount bits"); end
   if (VCNT_W < 8)         begin : g_bad_vcnt  $error("VCNT_W must be at least 8"); end
   if (CYC_W < VCNT_W)     begin : g_bad_cyc   $error("CYC_W must cover VCNT_W"); end
   if (ADDR_W < 15)        begin : g_bad_addr  $error("ADDR_W must be at least 15"); end

   disp_mode_t              mode_w;
   logic [CYC_W-1:0]        line_w;
   logic [TICK_W-1:0]       tick_w;
   logic [TICK_W-1:0]       hcnt_w;
   logic [VCNT_W-1:0]       vcnt_w;
   logic [ADDR_W-1:0]       addr_c;

   assign mode_w = '{text: mode_text_i, hires: mode_hires_i,
                     page2: mode_page2_i, store80: mode_store80_i};

   scan_line_split #(.CYC_W(CYC_W), .LINE_CYC(LINE_CYC)) split_i (
      .count_i (cyc_cnt_i),
      .line_o  (line_w),
      .tick_o  (tick_w)
   );

   scan_counter_derive #(.TICK_W(TICK_W), .VCNT_W(VCNT_W), .VBASE(VBASE)) derive_i (
      .tick_i  (tick_w),
      .line_i  (line_w[VCNT_W-1:0]),
      .hcnt_o  (hcnt_w),
      .vcnt_o  (vcnt_w)
   );

   display_addr_map #(.ADDR_W(ADDR_W), .SUM_K(SUM_K)) map_i (
      .hcnt_i  (hcnt_w[5:0]),
      .vcnt_i  (vcnt_w[7:0]),
      .mode_i  (mode_w),
      .addr_o  (addr_c)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_o   <= '0;
            rd_req_o <= 1'b0;
         end else begin
            rd_req_o <= probe_i;
            if (probe_i) addr_o <= addr_c;
         end
      end

      // R9: request follows the probe by exactly one cycle
      assert_req_follows_probe_R9: assert property (@(posedge clk) disable iff (!rst_n)
         probe_i |=> rd_req_o);
      assert_no_req_without_probe_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !probe_i |=> !rd_req_o);
      assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !probe_i |=> $stable(addr_o));
   end else begin : g_comb_out
      assign addr_o   = addr_c;
      assign rd_req_o = probe_i;
   end

   // R1: quotient and remainder rebuild the count, remainder below line length
   assert_split_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((32'(line_w) * LINE_CYC) + 32'(tick_w)) == 32'(cyc_cnt_i));
   assert_tick_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tick_w) < LINE_CYC);
   // R2: horizontal counter never exceeds the tick and stays below line length minus one
   assert_hcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hcnt_w <= tick_w) && (32'(hcnt_w) < LINE_CYC - 1));
   // R3: vertical counter minus the start offset gives back the line modulo 2^VCNT_W
   assert_vcnt_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vcnt_w - VCNT_W'(VBASE)) == line_w[VCNT_W-1:0]);
   // R6 R7: every produced address lies in one of the display pages of main memory
   assert_page_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_c >= ADDR_W'(16'h0400)) && (addr_c < ADDR_W'(16'h6000)));
endmodule

// File: tb/scan_addr_recon_tb.sv
module scan_addr_recon_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] cyc_cnt = '0;
   logic        m_text = 1'b1, m_hires = 1'b0, m_page2 = 1'b0, m_s80 = 1'b0;
   logic        probe = 1'b0;
   logic [15:0] addr;
   logic        rd_req;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scan_addr_recon dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_cnt_i(cyc_cnt),
      .mode_text_i(m_text), .mode_hires_i(m_hires),
      .mode_page2_i(m_page2), .mode_store80_i(m_s80),
      .probe_i(probe), .addr_o(addr), .rd_req_o(rd_req)
   );

   // model written from the requirements
   function automatic logic [15:0] model(int c, bit t, bit h, bit p, bit s);
      int line = c / 65;
      int tick = c % 65;
      int hc   = (tick == 0) ? 0 : tick - 1;
      int vc   = (line + 250) % 512;
      int v76  = (vc >> 6) & 3;
      int sm   = (13 + ((hc >> 3) & 7) + v76 * 4 + v76) & 15;
      int a    = (((vc >> 3) & 7) << 7) | (sm << 3) | (hc & 7);
      bit alt  = p && !s;
      if (t || !h) a |= alt ? 'h800 : 'h400;
      else         a |= (alt ? 'h4000 : 'h2000) | ((vc & 7) << 10);
      return a[15:0];
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // drive one probe and return the address seen with the request
   task automatic probe_at(int c, bit t, bit h, bit p, bit s, output logic [15:0] a);
      @(negedge clk);
      cyc_cnt = 15'(c); m_text = t; m_hires = h; m_page2 = p; m_s80 = s;
      probe = 1'b1;
      @(negedge clk);
      probe = 1'b0;
      chk("R9 req", 32'(rd_req), 1);
      a = addr;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10 req", 32'(rd_req), 0);
      chk("R10 addr", 32'(addr), 0);
   endtask

   task automatic t_boundary();
      logic [15:0] a;
      probe_at(64, 1, 0, 0, 0, a);
      chk("R1 count64", 32'(a), 32'(model(64, 1, 0, 0, 0)));
      probe_at(65, 1, 0, 0, 0, a);
      chk("R1 count65", 32'(a), 32'(model(65, 1, 0, 0, 0)));
      chk("R5 count0", 32'(model(0, 1, 0, 0, 0)), 32'h07E0);
      probe_at(0, 1, 0, 0, 0, a);
      chk("R5 count0 dut", 32'(a), 32'h07E0);
   endtask

   task automatic t_clamp();
      logic [15:0] a0, a1, a2;
      probe_at(130, 1, 0, 0, 0, a0);
      probe_at(131, 1, 0, 0, 0, a1);
      probe_at(132, 1, 0, 0, 0, a2);
      chk("R2 tick0 eq tick1", 32'(a1), 32'(a0));
      chk("R2 tick2", 32'(a2), 32'(a0) + 1);
      chk("R2 model", 32'(a2), 32'(model(132, 1, 0, 0, 0)));
   endtask

   task automatic t_vwrap();
      logic [15:0] a;
      probe_at(6*65 + 5, 0, 1, 0, 0, a);
      chk("R3 wrap line6", 32'(a), 32'(model(6*65 + 5, 0, 1, 0, 0)));
      probe_at(261*65 + 40, 0, 1, 0, 0, a);
      chk("R3 last line", 32'(a), 32'(model(261*65 + 40, 0, 1, 0, 0)));
   endtask

   task automatic t_sum();
      logic [15:0] a;
      for (int k = 0; k < 6; k++) begin
         int c = k * 1237 + 57;
         probe_at(c, 1, 0, 0, 0, a);
         chk("R4 sum sweep", 32'(a), 32'(model(c, 1, 0, 0, 0)));
      end
   endtask

   task automatic t_pages();
      logic [15:0] a;
      probe_at(700, 1, 0, 1, 0, a);
      chk("R6 text page2", 32'(a), 32'(model(700, 1, 0, 1, 0)));
      chk("R6 page2 bit", 32'(a[11:10]), 2);
      probe_at(700, 0, 0, 0, 0, a);
      chk("R6 lores page1", 32'(a[11:10]), 1);
      probe_at(5000, 0, 1, 0, 0, a);
      chk("R7 hires page1", 32'(a), 32'(model(5000, 0, 1, 0, 0)));
      probe_at(5000, 0, 1, 1, 0, a);
      chk("R7 hires page2", 32'(a), 32'(model(5000, 0, 1, 1, 0)));
      chk("R7 page2 bit14", 32'(a[14:13]), 2);
      probe_at(5000, 1, 1, 0, 0, a);
      chk("R6 text over hires", 32'(a), 32'(model(5000, 1, 0, 0, 0)));
   endtask

   task automatic t_store80();
      logic [15:0] a, b;
      probe_at(900, 1, 0, 0, 1, a);
      probe_at(900, 1, 0, 1, 1, b);
      chk("R8 text store80", 32'(b), 32'(a));
      probe_at(9000, 0, 1, 1, 1, b);
      chk("R8 hires store80", 32'(b), 32'(model(9000, 0, 1, 0, 0)));
   endtask

   task automatic t_hold();
      logic [15:0] a;
      probe_at(3333, 1, 0, 0, 0, a);
      cyc_cnt = 15'd77; m_text = 1'b0; m_hires = 1'b1;
      @(negedge clk);
      chk("R9 req drop", 32'(rd_req), 0);
      chk("R9 addr hold", 32'(addr), 32'(a));
      @(negedge clk);
      chk("R9 addr hold2", 32'(addr), 32'(model(3333, 1, 0, 0, 0)));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_boundary();
      t_clamp();
      t_vwrap();
      t_sum();
      t_pages();
      t_store80();
      t_hold();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule